// File: doc/BRIEF.md
# Fractional Nanosecond Time Counter

This block keeps a free-running time of day as a 64-bit count of nanoseconds. On every cycle of its clock, while enabled, it adds a programmable increment. The increment is a fixed-point number: 8 integer bits and 32 fraction bits of a nanosecond. Because of the fraction bits, clock periods that are not a whole number of nanoseconds accumulate without drift. Examples are 1.6 ns (0x01_99999999), 3.2 ns (0x03_33333333) and 32 ns (0x20_00000000). The full 64-bit time is also driven on an output bus for the timestamping logic nearby.

Software reaches the block through a simple 32-bit register port. The port has a control register, the time as two words and the increment as two words. Multi-word values move coherently in both directions:
- Reading the low time word captures the whole time, and a later high-word read returns the upper half of that capture.
- The low word of a write is held aside, and the value takes effect only when the high word is written.

Software can change the increment at run time, for example after a change of link rate or to trim the frequency. Writing an increment of zero halts the clock.

Top module: `tod_counter`

## Requirements
- R1: After synchronous reset, the time output is 0. The increment, enable bit and read data are also 0.
- R2: While the enable bit (control register at address 0, bit 0) is clear, the time does not change.
- R3: While enabled, each cycle adds the 40-bit increment to an accumulator that carries 32 fraction bits, and the time output is the integer part. With increment 0x01_99999999, the time after n cycles from zero is floor(n × 0x199999999 / 2^32), so after 5 cycles it is 7.
- R4: Writing the time low word (address 1) leaves the running time unchanged.
- R5: Writing the time high word (address 2) loads {written high word, pending low word} as the time. The loaded value is visible on the next cycle, that cycle's increment is skipped, and the fraction is cleared.
- R6: Reading the time low word (address 1) returns bits 31:0 of the current time and captures all 64 bits. A later read of the time high word (address 2) returns bits 63:32 of that capture, even if the counter has since moved on.
- R7: Writing the increment low word (address 3) does not change the active increment. Writing the increment high word (address 4) makes {wdata[7:0], pending low word} active, and it is first used on the cycle after that write.
- R8: With an active increment of zero, the time stays fixed even while enabled.
- R9: Read data appears one cycle after the read strobe. The control register reads back the enable in bit 0. Address 3 returns increment bits 31:0, and address 4 returns increment bits 39:32, zero-extended.
- R10: With increment 0x20_00000000, the time advances by exactly 32 on each enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one increment per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 time low, 2 time high, 3 increment low, 4 increment high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| tod_ns | output | 64 | Current time in nanoseconds |

## Verification
Every result of this block is due exactly one rising edge after its stimulus:
- A time commit shows on `tod_ns` after the high-word write edge.
- A new increment changes the step size starting with the edge that follows its commit.
- Read data appears after the edge that sampled the read strobe.

The bench applies each strobe for exactly one cycle, between falling edges, and compares on the next falling edge. This counts precisely how many increments went in between two samples, including the increment skipped on a load. The fractional sequences are checked against products computed in 96-bit arithmetic. This exposes truncation effects such as 5 × 1.6 ns reading as 7.

// File: rtl/tod_pkg.sv
package tod_pkg;

    parameter int REG_W     = 32;
    parameter int TIME_W    = 64;
    parameter int FRAC_W    = 32;
    parameter int INC_INT_W = 8;
    parameter int ADDR_W    = 3;

    localparam int INC_W = INC_INT_W + FRAC_W;
    localparam int ACC_W = TIME_W + FRAC_W;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL    = 3'd0,
        RA_TIME_LO = 3'd1,
        RA_TIME_HI = 3'd2,
        RA_INC_LO  = 3'd3,
        RA_INC_HI  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              load;
        logic [TIME_W-1:0] value;
    } time_load_t;

    function automatic logic [REG_W-1:0] pad_word(input logic [INC_INT_W-1:0] v);
        return {{(REG_W-INC_INT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/tod_regport.sv
module tod_regport
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [TIME_W-1:0] time_now,
    output logic [REG_W-1:0]  rdata,
    output logic              enable,
    output logic [INC_W-1:0]  inc,
    output time_load_t        ld
);

    logic [REG_W-1:0]  time_lo_pend;
    logic [REG_W-1:0]  inc_lo_pend;
    logic [TIME_W-1:0] snap;
    logic [INC_W-1:0]  inc_q;
    logic              en_q;
    logic [REG_W-1:0]  rdata_q;
    reg_addr_e         ra;

    assign ra = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            time_lo_pend <= '0;
            inc_lo_pend  <= '0;
            snap         <= '0;
            inc_q        <= '0;
            en_q         <= 1'b0;
            rdata_q      <= '0;
        end else begin
            if (wr) begin
                case (ra)
                    RA_CTRL:    en_q         <= wdata[0];
                    RA_TIME_LO: time_lo_pend <= wdata;
                    RA_INC_LO:  inc_lo_pend  <= wdata;
                    RA_INC_HI:  inc_q        <= {wdata[INC_INT_W-1:0], inc_lo_pend};
                    default:    ;
                endcase
            end
            if (rd) begin
                case (ra)
                    RA_CTRL:    rdata_q <= {{(REG_W-1){1'b0}}, en_q};
                    RA_TIME_LO: begin
                        snap    <= time_now;
                        rdata_q <= time_now[REG_W-1:0];
                    end
                    RA_TIME_HI: rdata_q <= snap[2*REG_W-1:REG_W];
                    RA_INC_LO:  rdata_q <= inc_q[FRAC_W-1:0];
                    RA_INC_HI:  rdata_q <= pad_word(inc_q[INC_W-1:FRAC_W]);
                    default:    rdata_q <= '0;
                endcase
            end
        end
    end

    always_comb begin
        ld.load  = wr && (ra == RA_TIME_HI);
        ld.value = {wdata, time_lo_pend};
    end

    assign rdata  = rdata_q;
    assign enable = en_q;
    assign inc    = inc_q;

    // R7: the active increment moves only on a high-word increment write
    assert_inc_held_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr && ra == RA_INC_HI) |=> $stable(inc_q));

    // R6: the capture changes only on a low-word time read
    assert_snap_held_R6: assert property (@(posedge clk) disable iff (rst)
        !(rd && ra == RA_TIME_LO) |=> $stable(snap));

endmodule

// File: rtl/tod_accum.sv
module tod_accum
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [INC_W-1:0]  inc,
    input  time_load_t        ld,
    output logic [TIME_W-1:0] time_ns
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] step;

    generate
        if (ACC_W > INC_W) begin : g_ext
            assign step = {{(ACC_W-INC_W){1'b0}}, inc};
        end else begin : g_same
            assign step = inc[ACC_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (ld.load) begin
            acc_q <= {ld.value, {FRAC_W{1'b0}}};
        end else if (enable) begin
            acc_q <= acc_q + step;
        end
    end

    assign time_ns = acc_q[ACC_W-1:FRAC_W];

    // R2: time holds while disabled and not loaded
    assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        (!enable && !ld.load) |=> $stable(time_ns));

    // R5: a commit lands exactly the written value
    assert_load_exact_R5: assert property (@(posedge clk) disable iff (rst)
        ld.load |=> (time_ns == $past(ld.value)));

    // R3: time never steps backwards while counting (away from wrap)
    assert_no_backstep_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && !ld.load && !time_ns[TIME_W-1]) |=> (time_ns >= $past(time_ns)));

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [TIME_W-1:0] tod_ns
);

    logic             enable;
    logic [INC_W-1:0] inc;
    time_load_t       ld;

    tod_regport u_regport (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .time_now (tod_ns),
        .rdata    (reg_rdata),
        .enable   (enable),
        .inc      (inc),
        .ld       (ld)
    );

    tod_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .inc     (inc),
        .ld      (ld),
        .time_ns (tod_ns)
    );

    // R4: a low-word time write alone leaves a stopped clock untouched
    assert_lo_write_inert_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_TIME_LO && !enable) |=> $stable(tod_ns));

    // R8: a zero increment freezes the time
    assert_zero_inc_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (inc == '0 && !ld.load) |=> $stable(tod_ns));

endmodule

// File: tb/sim_tod_counter.sv
module sim_tod_counter;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] tod_ns;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    tod_counter u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tod_ns    (tod_ns)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // each access starts and ends at a falling edge and spans one rising edge
    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1", "time after reset", tod_ns, 64'd0);
        chk("R1", "rdata after reset", {32'd0, reg_rdata}, 64'd0);
        rd_reg(3'd0, v); chk("R1", "enable after reset", {32'd0, v}, 64'd0);
        rd_reg(3'd3, v); chk("R1", "inc lo after reset", {32'd0, v}, 64'd0);
        rd_reg(3'd4, v); chk("R1", "inc hi after reset", {32'd0, v}, 64'd0);
    endtask

    task automatic t_hold_and_load;
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd4, 32'h20);
        repeat (5) @(negedge clk);
        chk("R2", "time while disabled", tod_ns, 64'd0);
        wr_reg(3'd1, 32'h1234);
        chk("R4", "time after low-word write", tod_ns, 64'd0);
        wr_reg(3'd2, 32'd0);
        chk("R5", "time after high-word commit", tod_ns, 64'h1234);
    endtask

    task automatic t_step32;
        logic [31:0] v;
        wr_reg(3'd0, 32'd1);
        chk("R10", "no step on enabling edge", tod_ns, 64'h1234);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            chk("R10", "32 ns step", tod_ns, 64'h1234 + 64'(32 * i));
        end
        rd_reg(3'd0, v);
        chk("R9", "ctrl readback", {32'd0, v}, 64'd1);
        rd_reg(3'd4, v);
        chk("R9", "inc hi readback", {32'd0, v}, 64'h20);
    endtask

    task automatic t_snapshot;
        logic [31:0] lo, hi;
        wr_reg(3'd1, 32'hFFFF_FFE0);
        wr_reg(3'd2, 32'h1);
        chk("R5", "load while running", tod_ns, 64'h1_FFFF_FFE0);
        rd_reg(3'd1, lo);
        chk("R6", "low word of capture", {32'd0, lo}, 64'hFFFF_FFE0);
        chk("R6", "counter crossed word", tod_ns, 64'h2_0000_0000);
        rd_reg(3'd2, hi);
        chk("R6", "high word from capture", {32'd0, hi}, 64'h1);
    endtask

    task automatic t_frac;
        logic [95:0] prod;
        wr_reg(3'd0, 32'd0);
        wr_reg(3'd1, 32'd0);
        wr_reg(3'd2, 32'd0);
        wr_reg(3'd3, 32'h9999_9999);
        wr_reg(3'd4, 32'h01);
        wr_reg(3'd0, 32'd1);
        chk("R3", "fractional start", tod_ns, 64'd0);
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            prod = 96'(n) * 96'h1_9999_9999;
            chk("R3", "1.6 ns accumulation", tod_ns, prod[95:32]);
        end
        wr_reg(3'd1, 32'd100);
        wr_reg(3'd2, 32'd0);
        chk("R5", "load with fraction pending", tod_ns, 64'd100);
        repeat (5) @(negedge clk);
        chk("R5", "fraction cleared by load", tod_ns, 64'd107);
    endtask

    task automatic t_inc_switch;
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd4, 32'h20);
        wr_reg(3'd1, 32'd1000);
        wr_reg(3'd2, 32'd0);
        chk("R5", "base for switch", tod_ns, 64'd1000);
        wr_reg(3'd3, 32'h9999_9999);
        chk("R7", "old inc after low write", tod_ns, 64'd1032);
        wr_reg(3'd4, 32'h01);
        chk("R7", "old inc on commit edge", tod_ns, 64'd1064);
        @(negedge clk);
        chk("R7", "new inc first tick", tod_ns, 64'd1065);
        @(negedge clk);
        chk("R7", "new inc second tick", tod_ns, 64'd1067);
    endtask

    task automatic t_zero;
        logic [63:0] t0;
        logic [31:0] v;
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd4, 32'd0);
        t0 = tod_ns;
        repeat (6) @(negedge clk);
        chk("R8", "zero increment halts", tod_ns, t0);
        rd_reg(3'd3, v); chk("R9", "inc lo reads zero", {32'd0, v}, 64'd0);
        rd_reg(3'd4, v); chk("R9", "inc hi reads zero", {32'd0, v}, 64'd0);
        rd_reg(3'd0, v); chk("R9", "still enabled", {32'd0, v}, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hold_and_load();
        t_step32();
        t_snapshot();
        t_frac();
        t_inc_switch();
        t_zero();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule